// File: doc/BRIEF.md
# UART Receive FIFO Interrupt Unit

This block sits next to the 16-entry receive FIFO of a 16550-style UART and decides when the receiver should ask the CPU for service. It compares the FIFO occupancy against a selectable trigger threshold and raises the received-data interrupt while the occupancy is at or above that threshold. It also runs a character time-out timer on the 16x baud clock enable, so that a few bytes left below the threshold still get noticed. Finally, it keeps the data-ready status flag.

The FIFO and the deserializer are outside the block. The block only observes them. It sees the occupancy count, a strobe for each character pushed by the shift register, and a strobe for each CPU read of the FIFO. No data word passes through the block, so it has no valid/ready stream interface. Every pin is a plain control or status level, or a single-cycle strobe that is sampled on each rising clock edge. A pending line-status request from the neighbouring status logic enters the block so that the identification code reports it with the highest priority.

Top module: `uart_rx_irq_unit`

## Requirements
- R1: The trigger select picks the threshold: 0 gives 1 byte, 1 gives 4, 2 gives 8 and 3 gives 14. On the clock edge after the occupancy is at or above the threshold, the received-data interrupt becomes pending, shown as `irq` = 1 and `irq_id` = 4'h4.
- R2: On the clock edge after the occupancy drops below the threshold, the received-data interrupt is no longer pending.
- R3: `data_ready` is 1 on the clock edge after a push strobe.
- R4: `data_ready` returns to 0 on the clock edge after a cycle in which the occupancy is 0 and no push occurs.
- R5: One frame has 1 start bit, 5 + `data_sel` data bits, 1 parity bit when parity is enabled, and 1 stop bit (2 stop bits when two stop bits are selected). While the FIFO is not empty, the time-out expires when the baud enable has been high for 64 × frame bits cycles with no push and no read. The expiry shows as `irq_id` = 4'hC in the cycle after the last of those ticks.
- R6: A push or a CPU read clears a pending time-out and restarts the tick count from zero.
- R7: An empty FIFO clears a pending time-out and holds the timer at zero.
- R8: Priority order: a line-status request gives 4'h6 and outranks received data (4'h4), which outranks time-out (4'hC). With nothing pending, `irq_id` is 4'h1 and `irq` is 0.
- R9: Received-data and time-out requests reach `irq` and `irq_id` only while both `fifo_en` and `rx_irq_en` are 1. Line-status requests are not gated by these bits.
- R10: During and right after reset, `irq` = 0, `irq_id` = 4'h1 and `data_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_count | input | 5 | Current receive FIFO occupancy |
| push | input | 1 | A character entered the FIFO this cycle |
| cpu_read | input | 1 | CPU read one character from the FIFO this cycle |
| baud_tick | input | 1 | 16x baud clock enable |
| data_sel | input | 2 | Data bits minus 5 |
| parity_en | input | 1 | Parity bit present |
| two_stop | input | 1 | Two stop bits |
| trig_sel | input | 2 | Trigger threshold select |
| fifo_en | input | 1 | FIFO mode enable |
| rx_irq_en | input | 1 | Receive interrupt enable |
| lsr_pending | input | 1 | Line-status interrupt request from the neighbouring status logic |
| irq | output | 1 | Interrupt request |
| irq_id | output | 4 | Interrupt identification code |
| data_ready | output | 1 | Receive data-ready status bit |

## Verification
The trigger hit, the time-out flag and `data_ready` are each held in one register. Their effects therefore show one clock edge after the stimulus that causes them. The enables and `lsr_pending` act on `irq` and `irq_id` in the same cycle. The bench changes inputs on falling edges and samples one falling edge after the rising edge that should update the result. For the time-out, the bench counts baud ticks itself. It checks that no expiry is reported after 64 × frame bits − 1 ticks and that the expiry is reported after exactly 64 × frame bits ticks, for several frame formats.

// File: rtl/uart_rx_irq_pkg.sv
package uart_rx_irq_pkg;

  typedef enum logic [3:0] {
    IID_NONE    = 4'h1,
    IID_RXDATA  = 4'h4,
    IID_LINE    = 4'h6,
    IID_TIMEOUT = 4'hC
  } iid_e;

  // Frame length in bit times: start + data + optional parity + stop(s).
  function automatic int unsigned frame_bits(input logic [1:0] data_sel,
                                             input logic parity_en,
                                             input logic two_stop);
    return 1 + 5 + int'(data_sel) + int'(parity_en) + (two_stop ? 2 : 1);
  endfunction

  // Trigger threshold in bytes for the 2-bit select.
  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/rx_trig_cmp.sv
module rx_trig_cmp #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [1:0]       trig_sel,
  output logic             hit_o
);
  import uart_rx_irq_pkg::*;

  logic [CNT_W-1:0] level;
  assign level = CNT_W'(trig_level(trig_sel));

  always_ff @(posedge clk) begin
    if (!rst_n) hit_o <= 1'b0;
    else        hit_o <= (fifo_count >= level);
  end
endmodule

// File: rtl/rx_char_timeout.sv
module rx_char_timeout #(
  parameter int CNT_W      = 5,
  parameter int TICKS_BIT  = 16,
  parameter int CHAR_TIMES = 4,
  parameter int MAX_FRAME  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             push,
  input  logic             cpu_read,
  input  logic             baud_tick,
  input  logic [1:0]       data_sel,
  input  logic             parity_en,
  input  logic             two_stop,
  output logic             expired_o
);
  import uart_rx_irq_pkg::*;

  localparam int UNIT  = TICKS_BIT * CHAR_TIMES;
  localparam int TMR_W = $clog2(UNIT * MAX_FRAME + 1);

  logic [TMR_W-1:0] ticks;
  logic [TMR_W-1:0] limit;
  logic             restart;

  assign limit   = TMR_W'(frame_bits(data_sel, parity_en, two_stop) * UNIT);
  assign restart = push | cpu_read | (fifo_count == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ticks     <= '0;
      expired_o <= 1'b0;
    end else if (restart) begin
      ticks     <= '0;
      expired_o <= 1'b0;
    end else if (baud_tick && !expired_o) begin
      if (ticks == limit - TMR_W'(1)) begin
        ticks     <= '0;
        expired_o <= 1'b1;
      end else begin
        ticks <= ticks + TMR_W'(1);
      end
    end
  end
endmodule

// File: rtl/rx_ready_flag.sv
module rx_ready_flag #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [CNT_W-1:0] fifo_count,
  output logic             ready_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ready_o <= 1'b0;
    else if (push) ready_o <= 1'b1;
    else if (fifo_count == '0) ready_o <= 1'b0;
  end
endmodule

// File: rtl/uart_rx_irq_unit.sv
module uart_rx_irq_unit #(
  parameter int DEPTH      = 16,
  parameter int TICKS_BIT  = 16,
  parameter int CHAR_TIMES = 4,
  localparam int CNT_W     = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             push,
  input  logic             cpu_read,
  input  logic             baud_tick,
  input  logic [1:0]       data_sel,
  input  logic             parity_en,
  input  logic             two_stop,
  input  logic [1:0]       trig_sel,
  input  logic             fifo_en,
  input  logic             rx_irq_en,
  input  logic             lsr_pending,
  output logic             irq,
  output logic [3:0]       irq_id,
  output logic             data_ready
);
  import uart_rx_irq_pkg::*;

  logic trig_hit, tmo_hit, rx_active;
  iid_e id_sel;

  rx_trig_cmp #(.CNT_W(CNT_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count),
    .trig_sel(trig_sel), .hit_o(trig_hit));

  rx_char_timeout #(.CNT_W(CNT_W), .TICKS_BIT(TICKS_BIT),
                    .CHAR_TIMES(CHAR_TIMES), .MAX_FRAME(12)) u_tmo (
    .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count), .push(push),
    .cpu_read(cpu_read), .baud_tick(baud_tick), .data_sel(data_sel),
    .parity_en(parity_en), .two_stop(two_stop), .expired_o(tmo_hit));

  rx_ready_flag #(.CNT_W(CNT_W)) u_dr (
    .clk(clk), .rst_n(rst_n), .push(push), .fifo_count(fifo_count),
    .ready_o(data_ready));

  assign rx_active = fifo_en & rx_irq_en;

  always_comb begin
    if (lsr_pending)                 id_sel = IID_LINE;
    else if (rx_active && trig_hit)  id_sel = IID_RXDATA;
    else if (rx_active && tmo_hit)   id_sel = IID_TIMEOUT;
    else                             id_sel = IID_NONE;
  end

  assign irq_id = id_sel;
  assign irq    = (id_sel != IID_NONE);
endmodule

// File: rtl/uart_rx_irq_checker.sv
module uart_rx_irq_checker #(
  parameter int CNT_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] fifo_count,
  input logic             push,
  input logic             cpu_read,
  input logic [1:0]       trig_sel,
  input logic             fifo_en,
  input logic             rx_irq_en,
  input logic             lsr_pending,
  input logic             irq,
  input logic [3:0]       irq_id,
  input logic             data_ready
);
  import uart_rx_irq_pkg::*;

  logic past_ok;
  always_ff @(posedge clk) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  a_r1_level_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && fifo_en && rx_irq_en && !lsr_pending &&
     int'($past(fifo_count)) >= int'(trig_level($past(trig_sel)))) |-> (irq_id == 4'h4));

  a_r2_level_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && int'($past(fifo_count)) < int'(trig_level($past(trig_sel)))) |-> (irq_id != 4'h4));

  a_r3_ready_set: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> data_ready);

  a_r4_ready_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (!push && fifo_count == '0) |=> !data_ready);

  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (push || cpu_read) |=> (irq_id != 4'hC));

  a_r7_empty: assert property (@(posedge clk) disable iff (!rst_n)
    (fifo_count == '0) |=> (irq_id != 4'hC));

  a_r8_line_first: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_pending |-> (irq && irq_id == 4'h6));

  a_r9_gated: assert property (@(posedge clk) disable iff (!rst_n)
    (!(fifo_en && rx_irq_en) && !lsr_pending) |-> (!irq && irq_id == 4'h1));
endmodule

bind uart_rx_irq_unit uart_rx_irq_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count), .push(push),
  .cpu_read(cpu_read), .trig_sel(trig_sel), .fifo_en(fifo_en),
  .rx_irq_en(rx_irq_en), .lsr_pending(lsr_pending), .irq(irq),
  .irq_id(irq_id), .data_ready(data_ready));

// File: tb/uart_rx_irq_unit_test.sv
module uart_rx_irq_unit_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] fifo_count = '0;
  logic       push = 1'b0, cpu_read = 1'b0, baud_tick = 1'b0;
  logic [1:0] data_sel = 2'd3;
  logic       parity_en = 1'b0, two_stop = 1'b0;
  logic [1:0] trig_sel = 2'd3;
  logic       fifo_en = 1'b1, rx_irq_en = 1'b1, lsr_pending = 1'b0;
  logic       irq, data_ready;
  logic [3:0] irq_id;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  uart_rx_irq_unit uut (
    .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count), .push(push),
    .cpu_read(cpu_read), .baud_tick(baud_tick), .data_sel(data_sel),
    .parity_en(parity_en), .two_stop(two_stop), .trig_sel(trig_sel),
    .fifo_en(fifo_en), .rx_irq_en(rx_irq_en), .lsr_pending(lsr_pending),
    .irq(irq), .irq_id(irq_id), .data_ready(data_ready));

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, actual, expected, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    step(2);
    check("R10 irq in reset", irq, 0);
    check("R10 id in reset", irq_id, 4'h1);
    check("R10 dr in reset", data_ready, 0);
    rst_n = 1'b1;
    step(1);
    check("R10 id after reset", irq_id, 4'h1);
    check("R10 dr after reset", data_ready, 0);
  endtask

  task automatic t_levels;
    for (int s = 0; s < 4; s++) begin
      int lvl;
      lvl = (s == 0) ? 1 : (s == 1) ? 4 : (s == 2) ? 8 : 14;
      trig_sel = 2'(s);
      fifo_count = 5'(lvl - 1);
      step(1);
      check("R2 below level", irq_id, 4'h1);
      fifo_count = 5'(lvl);
      step(1);
      check("R1 at level id", irq_id, 4'h4);
      check("R1 at level irq", irq, 1);
      fifo_count = 5'(lvl + 1);
      step(1);
      check("R1 above level", irq_id, 4'h4);
      fifo_count = 5'(lvl - 1);
      step(1);
      check("R2 dropped below", irq_id, 4'h1);
    end
    fifo_count = '0;
    trig_sel = 2'd3;
    step(1);
  endtask

  task automatic t_ready;
    push = 1'b1;
    step(1);
    check("R3 set on push", data_ready, 1);
    push = 1'b0;
    fifo_count = 5'd2;
    step(1);
    check("R4 held nonempty", data_ready, 1);
    fifo_count = 5'd0;
    push = 1'b1;
    step(1);
    check("R3 push wins over empty", data_ready, 1);
    push = 1'b0;
    step(1);
    check("R4 clear on empty", data_ready, 0);
  endtask

  task automatic t_timeout(input logic [1:0] ds, input logic pe, input logic ts, input int fbits);
    int lim;
    lim = 64 * fbits;
    data_sel = ds; parity_en = pe; two_stop = ts; trig_sel = 2'd3;
    fifo_count = 5'd1; push = 1'b1;
    step(1);
    push = 1'b0; baud_tick = 1'b1;
    step(lim - 1);
    check("R5 not yet expired", irq_id, 4'h1);
    step(1);
    check("R5 expired id", irq_id, 4'hC);
    check("R5 expired irq", irq, 1);
    cpu_read = 1'b1;
    step(1);
    check("R6 read clears", irq_id, 4'h1);
    cpu_read = 1'b0;
    step(lim - 1);
    check("R6 restarted by read", irq_id, 4'h1);
    push = 1'b1; fifo_count = 5'd2;
    step(1);
    push = 1'b0;
    step(lim - 1);
    check("R6 restarted by push", irq_id, 4'h1);
    step(1);
    check("R5 expired again", irq_id, 4'hC);
    fifo_count = 5'd14;
    step(1);
    check("R8 data over timeout", irq_id, 4'h4);
    lsr_pending = 1'b1;
    step(1);
    check("R8 line status first", irq_id, 4'h6);
    lsr_pending = 1'b0;
    fifo_count = 5'd2;
    step(1);
    check("R8 timeout visible", irq_id, 4'hC);
    fifo_count = 5'd0;
    step(1);
    check("R7 empty clears", irq_id, 4'h1);
    step(lim + 2);
    check("R7 stays clear", irq_id, 4'h1);
    baud_tick = 1'b0;
  endtask

  task automatic t_gating;
    trig_sel = 2'd0; fifo_count = 5'd3;
    rx_irq_en = 1'b0;
    step(1);
    check("R9 rx irq disabled", irq, 0);
    check("R9 rx irq disabled id", irq_id, 4'h1);
    lsr_pending = 1'b1;
    step(1);
    check("R9 line status ungated", irq_id, 4'h6);
    lsr_pending = 1'b0; rx_irq_en = 1'b1; fifo_en = 1'b0;
    step(1);
    check("R9 fifo disabled", irq, 0);
    fifo_en = 1'b1;
    step(1);
    check("R9 re-enabled", irq_id, 4'h4);
    fifo_count = '0;
    step(1);
  endtask

  initial begin
    t_reset;
    t_levels;
    t_ready;
    t_timeout(2'd3, 1'b0, 1'b0, 10);
    t_timeout(2'd0, 1'b0, 1'b0, 7);
    t_timeout(2'd3, 1'b1, 1'b1, 12);
    t_gating;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1000000;
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule